// File: doc/BRIEF.md
# Indirect Access Window

This block lets a host reach storage that is not mapped into its own address space. The host sees eight 32-bit registers, selected by a word index. For the internal SRAM there are two pointers, one for reads and one for writes. The host first loads a pointer. It then moves data through a data register, and every data access steps the pointer on by one 32-bit word.

A second pair of address registers serves a peripheral register bus. Each of these holds a 16-bit register offset and a two-bit field that gives the byte count minus one. These address registers hold their value after an access. Only an access to a data register starts a transfer on the SRAM or on the peripheral bus. A read of internal data stalls the host port for one cycle while the synchronous storage answers.

Register map (word index): 0 read pointer, 1 write pointer, 2 memory write data, 3 memory read data, 4 peripheral read address, 5 peripheral write address, 6 peripheral write data, 7 peripheral read data.

Top module: `ind_win`

## Requirements
- R1: After reset the host port is ready, no read response is pending, neither internal bus is enabled, and both memory pointers and both peripheral address registers read back as zero.
- R2: A host write to index 0 or 1 loads the read or write pointer with bits AW+1:2 of the data. Reading the pointer returns the word index shifted left by two, with all other bits zero. Any register read other than index 3 and 7 is answered with host_rvalid in the cycle after it is accepted.
- R3: A host write to index 2 drives, in the same cycle, exactly one SRAM write at the write pointer's word index with the host data, and the write pointer then advances by one word.
- R4: A host read of index 3 drives, in the same cycle, one SRAM read at the read pointer's word index. host_rdy is low in the next cycle, and the SRAM word is returned with host_rvalid two cycles after acceptance. The read pointer then advances by one word.
- R5: A pointer that advances from the last SRAM word wraps to word zero.
- R6: Data accesses move only their own pointer: writes leave the read pointer unchanged, and reads leave the write pointer unchanged.
- R7: The peripheral address registers (index 4 read, index 5 write) keep bits 15:0 as the offset and bits 25:24 as the byte count minus one. All other bits read back as zero, and the registers do not change on data accesses.
- R8: A host write to index 6 drives one peripheral write at the write-address offset with the host data. The byte enables cover the lowest count+1 bytes (count 0: 0001, 1: 0011, 2: 0111, 3: 1111).
- R9: A host read of index 7 drives one peripheral read at the read-address offset with the same byte-enable coding. The response comes two cycles after acceptance, and bytes above the count read as zero.
- R10: Host writes to index 3 or 7 have no effect, and host reads of index 2 or 6 return zero. Neither of these starts a bus transfer.
- R11: A host request while host_rdy is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host request, accepted when host_rdy is high |
| host_wr | input | 1 | 1 write, 0 read |
| host_widx | input | 3 | Register word index |
| host_wdata | input | 32 | Host write data |
| host_rdy | output | 1 | Port can accept a request |
| host_rvalid | output | 1 | Read response valid |
| host_rdata | output | 32 | Read response data |
| sram_en | output | 1 | SRAM access strobe |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | AW | SRAM word address |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, valid one cycle after a read |
| prph_en | output | 1 | Peripheral access strobe |
| prph_we | output | 1 | Peripheral write enable |
| prph_addr | output | 16 | Peripheral register offset |
| prph_be | output | 4 | Peripheral byte enables |
| prph_wdata | output | 32 | Peripheral write data |
| prph_rdata | input | 32 | Peripheral read data, valid one cycle after a read |

## Verification
The bench builds the block with MEM_WORDS set to 16, so AW is 4. With that size, a short burst of data accesses carries both pointers across the top word and back to zero. A pointer value written with high bits set also shows which bits are dropped. The peripheral side is exercised with all four byte counts against a 16-entry storage model. During each read stall the bench drives a request, which shows that the stall cycle ignores host traffic.

// File: rtl/ind_win_pkg.sv
// Package: shared register indices, wait states and byte-lane helpers
// for the indirect access window.
package ind_win_pkg;

    localparam int DW = 32;
    localparam int PRPH_OW = 16;

    // Host register word indices
    typedef enum logic [2:0] {
        SEL_MEM_RPTR  = 3'd0,
        SEL_MEM_WPTR  = 3'd1,
        SEL_MEM_WDAT  = 3'd2,
        SEL_MEM_RDAT  = 3'd3,
        SEL_PRPH_RADR = 3'd4,
        SEL_PRPH_WADR = 3'd5,
        SEL_PRPH_WDAT = 3'd6,
        SEL_PRPH_RDAT = 3'd7
    } reg_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_MEM_WAIT  = 2'd1,
        ST_PRPH_WAIT = 2'd2
    } win_state_t;

    // Byte enables for the lowest cnt+1 bytes
    function automatic logic [3:0] be_of(input logic [1:0] cnt);
        case (cnt)
            2'd0:    be_of = 4'b0001;
            2'd1:    be_of = 4'b0011;
            2'd2:    be_of = 4'b0111;
            default: be_of = 4'b1111;
        endcase
    endfunction

    // Expand byte enables into a bit mask
    function automatic logic [DW-1:0] mask_of(input logic [3:0] be);
        mask_of = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

endpackage

// File: rtl/ind_win_ptr.sv
// Module: word-index pointer for the SRAM window.
// Loads from the host, or steps by one word on each data access.
// Assumes the SRAM depth is a power of two, so the step wraps to zero.
module ind_win_ptr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] idx
);

    logic [AW-1:0] idx_q;

    // Pointer register: load has priority over advance
    always_ff @(posedge clk) begin
        if (!rst_n)    idx_q <= '0;
        else if (load) idx_q <= load_val;
        else if (adv)  idx_q <= idx_q + 1'b1;
    end

    assign idx = idx_q;

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && idx_q == '1) |=> idx_q == '0);

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(idx_q));

endmodule

// File: rtl/ind_win_prph_reg.sv
// Module: one peripheral address register (offset plus byte count).
// Holds its value until the host reloads it; it never steps.
module ind_win_prph_reg
    import ind_win_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DW-1:0]      wval,
    output logic [PRPH_OW-1:0] off,
    output logic [3:0]         be,
    output logic [DW-1:0]      rdback
);

    logic [PRPH_OW-1:0] off_q;
    logic [1:0]         cnt_q;
    logic               unused_bits;

    // Capture offset (15:0) and count-minus-one (25:24)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            off_q <= wval[15:0];
            cnt_q <= wval[25:24];
        end
    end

    assign off         = off_q;
    assign be          = be_of(cnt_q);
    assign rdback      = {6'b0, cnt_q, 8'b0, off_q};
    assign unused_bits = ^{wval[31:26], wval[23:16]};

    // R7
    prph_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(off_q) && $stable(cnt_q)));

endmodule

// File: rtl/ind_win.sv
// Module: indirect access window top.
// Decodes host register accesses and drives the SRAM and peripheral buses.
// Assumes both buses return read data exactly one cycle after a read strobe,
// and that no other master shares them.
module ind_win
    import ind_win_pkg::*;
#(
    parameter int MEM_WORDS = 1024,
    localparam int AW = $clog2(MEM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [2:0]         host_widx,
    input  logic [DW-1:0]      host_wdata,
    output logic               host_rdy,
    output logic               host_rvalid,
    output logic [DW-1:0]      host_rdata,
    output logic               sram_en,
    output logic               sram_we,
    output logic [AW-1:0]      sram_addr,
    output logic [DW-1:0]      sram_wdata,
    input  logic [DW-1:0]      sram_rdata,
    output logic               prph_en,
    output logic               prph_we,
    output logic [PRPH_OW-1:0] prph_addr,
    output logic [3:0]         prph_be,
    output logic [DW-1:0]      prph_wdata,
    input  logic [DW-1:0]      prph_rdata
);

    win_state_t st_q;
    reg_sel_t   sel;
    logic       acc, acc_wr, acc_rd;
    logic       rvalid_q;
    logic [DW-1:0] rdata_q, reg_val;

    logic [1:0]    ptr_load, ptr_adv;
    logic [AW-1:0] ptr_idx [2];

    logic [1:0]         pa_load;
    logic [PRPH_OW-1:0] pa_off [2];
    logic [3:0]         pa_be  [2];
    logic [DW-1:0]      pa_rb  [2];
    logic               unused_wbits;

    assign sel      = reg_sel_t'(host_widx);
    assign host_rdy = (st_q == ST_IDLE);
    assign acc      = host_req && host_rdy;
    assign acc_wr   = acc && host_wr;
    assign acc_rd   = acc && !host_wr;

    // Pointer controls: entry 0 read pointer, entry 1 write pointer
    assign ptr_load[0] = acc_wr && (sel == SEL_MEM_RPTR);
    assign ptr_load[1] = acc_wr && (sel == SEL_MEM_WPTR);
    assign ptr_adv[0]  = acc_rd && (sel == SEL_MEM_RDAT);
    assign ptr_adv[1]  = acc_wr && (sel == SEL_MEM_WDAT);
    assign pa_load[0]  = acc_wr && (sel == SEL_PRPH_RADR);
    assign pa_load[1]  = acc_wr && (sel == SEL_PRPH_WADR);

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_chan
            ind_win_ptr #(.AW(AW)) u_ptr (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (ptr_load[g]),
                .load_val (host_wdata[AW+1:2]),
                .adv      (ptr_adv[g]),
                .idx      (ptr_idx[g])
            );
            ind_win_prph_reg u_pa (
                .clk    (clk),
                .rst_n  (rst_n),
                .load   (pa_load[g]),
                .wval   (host_wdata),
                .off    (pa_off[g]),
                .be     (pa_be[g]),
                .rdback (pa_rb[g])
            );
        end
    endgenerate

    assign unused_wbits = ^{host_wdata[DW-1:AW+2], host_wdata[1:0]};

    // SRAM strobe on data-register accesses only
    assign sram_en    = ptr_adv[0] || ptr_adv[1];
    assign sram_we    = host_wr;
    assign sram_addr  = host_wr ? ptr_idx[1] : ptr_idx[0];
    assign sram_wdata = host_wdata;

    // Peripheral strobe on data-register accesses only
    assign prph_en    = (acc_wr && sel == SEL_PRPH_WDAT) || (acc_rd && sel == SEL_PRPH_RDAT);
    assign prph_we    = host_wr;
    assign prph_addr  = host_wr ? pa_off[1] : pa_off[0];
    assign prph_be    = host_wr ? pa_be[1]  : pa_be[0];
    assign prph_wdata = host_wdata;

    // Readback value for plain register reads
    always_comb begin
        case (sel)
            SEL_MEM_RPTR:  reg_val = DW'(ptr_idx[0]) << 2;
            SEL_MEM_WPTR:  reg_val = DW'(ptr_idx[1]) << 2;
            SEL_PRPH_RADR: reg_val = pa_rb[0];
            SEL_PRPH_WADR: reg_val = pa_rb[1];
            default:       reg_val = '0;
        endcase
    end

    // Response state: one stall cycle for bus reads, else answer next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= 1'b0;
            case (st_q)
                ST_MEM_WAIT: begin
                    rdata_q  <= sram_rdata;
                    rvalid_q <= 1'b1;
                    st_q     <= ST_IDLE;
                end
                ST_PRPH_WAIT: begin
                    rdata_q  <= prph_rdata & mask_of(pa_be[0]);
                    rvalid_q <= 1'b1;
                    st_q     <= ST_IDLE;
                end
                default: begin
                    if (acc_rd) begin
                        if (sel == SEL_MEM_RDAT)       st_q <= ST_MEM_WAIT;
                        else if (sel == SEL_PRPH_RDAT) st_q <= ST_PRPH_WAIT;
                        else begin
                            rdata_q  <= reg_val;
                            rvalid_q <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign host_rvalid = rvalid_q;
    assign host_rdata  = rdata_q;

    // R4
    mem_rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && !sram_we) |=> (!host_rdy ##1 host_rvalid));

    // R2
    reg_rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_rdy && !host_wr && host_widx != 3'd3 && host_widx != 3'd7)
        |=> (host_rvalid && host_rdy));

    // R10
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_en && prph_en));

    // R8
    prph_be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prph_en |-> (prph_be[0] && $countones(prph_be + 4'd1) <= 1));

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rdy |-> (!sram_en && !prph_en && !host_rvalid));

endmodule

// File: tb/sim_ind_win.sv
// Bench: behavioural reference model of the window, checked each cycle of
// every host transaction, with small SRAM and peripheral storage models.
module sim_ind_win;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 16;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0, host_wr = 1'b0;
    logic [2:0] host_widx = '0;
    logic [31:0] host_wdata = '0;
    logic host_rdy, host_rvalid;
    logic [31:0] host_rdata;
    logic sram_en, sram_we;
    logic [AW-1:0] sram_addr;
    logic [31:0] sram_wdata, sram_rdata;
    logic prph_en, prph_we;
    logic [15:0] prph_addr;
    logic [3:0] prph_be;
    logic [31:0] prph_wdata, prph_rdata;

    int nchk = 0, nerr = 0;

    // Storage environment
    logic [31:0] env_mem [WORDS];
    logic [31:0] env_prph [16];
    // Reference model state
    logic [31:0] ref_mem [WORDS];
    logic [31:0] ref_prph [16];
    int rptr = 0, wptr = 0;
    logic [15:0] pr_off = '0, pw_off = '0;
    logic [1:0]  pr_cnt = '0, pw_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ind_win #(.MEM_WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_widx(host_widx), .host_wdata(host_wdata), .host_rdy(host_rdy),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .prph_en(prph_en), .prph_we(prph_we), .prph_addr(prph_addr),
        .prph_be(prph_be), .prph_wdata(prph_wdata), .prph_rdata(prph_rdata)
    );

    initial begin
        for (int i = 0; i < 16; i++) begin
            env_mem[i]  = 32'hA500_0000 + i;
            ref_mem[i]  = 32'hA500_0000 + i;
            env_prph[i] = 32'h5A00_0000 + i;
            ref_prph[i] = 32'h5A00_0000 + i;
        end
    end

    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) env_mem[sram_addr] <= sram_wdata;
            sram_rdata <= env_mem[sram_addr];
        end
        if (prph_en) begin
            if (prph_we)
                for (int b = 0; b < 4; b++)
                    if (prph_be[b]) env_prph[prph_addr[3:0]][b*8 +: 8] <= prph_wdata[b*8 +: 8];
            prph_rdata <= env_prph[prph_addr[3:0]];
        end
    end

    function automatic logic [3:0] exp_be(input logic [1:0] c);
        return 4'((1 << (int'(c) + 1)) - 1);
    endfunction

    function automatic logic [31:0] exp_mask(input logic [1:0] c);
        logic [31:0] m;
        m = '0;
        for (int b = 0; b <= int'(c); b++) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input int w, input logic [31:0] d, input string tag);
        logic [31:0] exp;
        bit slow;
        exp = '0;
        slow = 0;
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_widx = 3'(w); host_wdata = d;
        #1;
        chk({tag, " rdy"}, 32'(host_rdy), 1);
        if (wr) begin
            case (w)
                2: begin
                    chk({tag, " R3 sram"}, {sram_en, sram_we, prph_en}, 32'b110);
                    chk({tag, " R3 addr"}, 32'(sram_addr), 32'(wptr));
                    chk({tag, " R3 data"}, sram_wdata, d);
                    ref_mem[wptr] = d;
                    wptr = (wptr + 1) % WORDS;
                end
                6: begin
                    chk({tag, " R8 strobe"}, {sram_en, prph_en, prph_we}, 32'b011);
                    chk({tag, " R8 addr"}, 32'(prph_addr), 32'(pw_off));
                    chk({tag, " R8 be"}, 32'(prph_be), 32'(exp_be(pw_cnt)));
                    chk({tag, " R8 data"}, prph_wdata, d);
                    ref_prph[pw_off[3:0]] = (ref_prph[pw_off[3:0]] & ~exp_mask(pw_cnt)) | (d & exp_mask(pw_cnt));
                end
                default: begin
                    chk({tag, " R10 no bus"}, {sram_en, prph_en}, 0);
                    if (w == 0) rptr = int'(d[5:2]);
                    if (w == 1) wptr = int'(d[5:2]);
                    if (w == 4) begin pr_off = d[15:0]; pr_cnt = d[25:24]; end
                    if (w == 5) begin pw_off = d[15:0]; pw_cnt = d[25:24]; end
                end
            endcase
        end else begin
            case (w)
                3: begin
                    chk({tag, " R4 sram"}, {sram_en, sram_we, prph_en}, 32'b100);
                    chk({tag, " R4 addr"}, 32'(sram_addr), 32'(rptr));
                    exp = ref_mem[rptr];
                    rptr = (rptr + 1) % WORDS;
                    slow = 1;
                end
                7: begin
                    chk({tag, " R9 strobe"}, {sram_en, prph_en, prph_we}, 32'b010);
                    chk({tag, " R9 addr"}, 32'(prph_addr), 32'(pr_off));
                    chk({tag, " R9 be"}, 32'(prph_be), 32'(exp_be(pr_cnt)));
                    exp = ref_prph[pr_off[3:0]] & exp_mask(pr_cnt);
                    slow = 1;
                end
                default: begin
                    chk({tag, " R10 no bus"}, {sram_en, prph_en}, 0);
                    case (w)
                        0: exp = 32'(rptr * 4);
                        1: exp = 32'(wptr * 4);
                        4: exp = {6'b0, pr_cnt, 8'b0, pr_off};
                        5: exp = {6'b0, pw_cnt, 8'b0, pw_off};
                        default: exp = '0;
                    endcase
                end
            endcase
        end
        @(negedge clk);
        if (slow) begin
            // R11: request during the stall, must be ignored
            host_wr = 1'b1; host_widx = 3'd1; host_wdata = 32'h0000_0024;
            #1;
            chk({tag, " R4 stall rdy"}, {host_rdy, host_rvalid}, 0);
            chk({tag, " R11 no bus"}, {sram_en, prph_en}, 0);
            @(negedge clk);
        end
        host_req = 1'b0;
        chk({tag, " rvalid"}, 32'(host_rvalid), wr ? 0 : 1);
        if (!wr) chk({tag, " rdata"}, host_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk("R1 rdy", 32'(host_rdy), 1);
        chk("R1 quiet", {host_rvalid, sram_en, prph_en}, 0);
        xfer(0, 0, 0, "R1 rptr");
        xfer(0, 1, 0, "R1 wptr");
        xfer(0, 4, 0, "R1 praddr");
        xfer(0, 5, 0, "R1 pwaddr");
        // R2: pointer load keeps only the word-index bits
        xfer(1, 0, 32'h1234_5678, "R2 load");
        xfer(0, 0, 0, "R2 rptr readback");
        // R3/R5: writes across the top word
        xfer(1, 1, 32'h0000_003C, "R5 wptr top");
        xfer(1, 2, 32'hCAFE_0001, "R3 w0");
        xfer(1, 2, 32'hCAFE_0002, "R5 w1 wrapped");
        xfer(1, 2, 32'hCAFE_0003, "R3 w2");
        xfer(0, 0, 0, "R6 rptr untouched");
        // R4/R5: reads across the top word
        xfer(1, 0, 32'h0000_0038, "R4 rptr");
        for (int k = 0; k < 4; k++) xfer(0, 3, 0, "R4 read");
        xfer(0, 0, 0, "R5 rptr after wrap");
        xfer(0, 1, 0, "R6 R11 wptr untouched");
        // R10
        xfer(1, 3, 32'hDEAD_BEEF, "R10 write rdat");
        xfer(1, 7, 32'hDEAD_BEEF, "R10 write prdat");
        xfer(0, 2, 0, "R10 read wdat");
        xfer(0, 6, 0, "R10 read pwdat");
        xfer(0, 0, 0, "R10 rptr kept");
        // R7/R8
        xfer(1, 5, 32'hFF03_0005, "R7 pwaddr");
        xfer(0, 5, 0, "R7 pwaddr readback");
        xfer(1, 6, 32'h1122_3344, "R8 full");
        xfer(1, 5, 32'h0000_0005, "R8 cnt0");
        xfer(1, 6, 32'hAABB_CCDD, "R8 byte");
        xfer(1, 5, 32'h0100_0006, "R8 cnt1");
        xfer(1, 6, 32'h9988_7766, "R8 half");
        xfer(1, 5, 32'h0200_0007, "R8 cnt2");
        xfer(1, 6, 32'h0102_0304, "R8 three");
        xfer(0, 5, 0, "R7 no step");
        // R9
        for (int c = 0; c < 4; c++) begin
            xfer(1, 4, {6'b0, 2'(c), 8'hEE, 16'h0005}, "R9 praddr");
            xfer(0, 7, 0, "R9 read");
        end
        xfer(1, 4, 32'h0300_0007, "R9 praddr 7");
        xfer(0, 7, 0, "R9 read 7");
        xfer(0, 7, 0, "R7 R9 repeat");
        xfer(0, 4, 0, "R7 praddr kept");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule